// File: doc/BRIEF.md
# Pixel Blend and Raster-Op Stage

This block merges two pixels, a destination and a source, into one output pixel. Each pixel carries four channels of `CH_W` bits. Alpha sits in the top byte, bits [31:24]. The colour channels sit in bits [23:16], [15:8] and [7:0]. A static mode input chooses the operation. When it is clear, each bit of the output is a logic function of the matching source and destination bits. A 4-bit code picks that function, and the colour channels and the alpha channel have separate codes. When the mode input is set, each channel is a weighted sum of the two inputs, rescaled to the 0..255 range. Each of the two weights comes from a menu of alpha-derived values or a programmable coefficient.

Pixel pairs enter on a valid/ready handshake and results leave on a second one. The stage is a two-register pipeline with a fixed latency and a global stall. A typical use puts several stages in a chain to build a layer compositor. A stage whose layer is unused is set to the pass-through code, so the destination flows on untouched.

Top module: `pix_combine`

## Requirements
- R1: A pair accepted at a clock edge (`inValid` and `inReady` both high) appears on `outPix` with `outValid` high two edges later, provided `outReady` is high. Results leave in acceptance order.
- R2: While `outValid` is high and `outReady` is low, `outValid` and `outPix` hold their values. `inReady` is low only in that case.
- R3: While `rst_n` is low and on the first edge after it rises, `outValid` is low.
- R4: With `cfgBlend`=0, each colour bit is f(S,D) for code `cfgColorOp`: 0 D, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 0, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), 10 ~D, 11 S|~D, 12 ~S, 13 ~S|D, 14 ~(S&D), 15 1.
- R5: With `cfgBlend`=0, the alpha byte [31:24] uses `cfgAlphaOp` with the same encoding as R4, independently of the colour code.
- R6: Code 0 on both channel groups passes `inDst` through unchanged for any `inSrc`.
- R7: With `cfgBlend`=1, each channel is computed from p = X*D + Y*S as min(255, (p+128+((p+128)>>8))>>8). Two examples: X=255, Y=255 with D=S=255 gives 255, and X=128 with D=1 and Y=0 gives 1.
- R8: Weight selects use this encoding: 0 destination alpha, 1 255 minus destination alpha, 2 source alpha, 3 255 minus source alpha, 4 fixed coefficient, 5..7 zero. The colour channels use `cfgColXSel`/`cfgColYSel` and the alpha channel uses `cfgAlpXSel`/`cfgAlpYSel`.
- R9: Select 4 gives `cfgCoefX` when it drives an X weight and `cfgCoefY` when it drives a Y weight.
- R10: Selects colour X=3, Y=2, alpha X=3, Y=4 with `cfgCoefY`=255 produce source-over compositing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfgBlend | input | 1 | 1 = weighted blend, 0 = bitwise logic |
| cfgColorOp | input | 4 | Logic code for the colour channels |
| cfgAlphaOp | input | 4 | Logic code for the alpha channel |
| cfgColXSel | input | 3 | Colour destination weight select |
| cfgColYSel | input | 3 | Colour source weight select |
| cfgAlpXSel | input | 3 | Alpha destination weight select |
| cfgAlpYSel | input | 3 | Alpha source weight select |
| cfgCoefX | input | 8 | Fixed X weight |
| cfgCoefY | input | 8 | Fixed Y weight |
| inValid | input | 1 | Input pair valid |
| inReady | output | 1 | Stage can accept a pair |
| inDst | input | 32 | Destination pixel |
| inSrc | input | 32 | Source pixel |
| outValid | output | 1 | Result valid |
| outReady | input | 1 | Downstream accepts the result |
| outPix | output | 32 | Result pixel |

## Verification
A corrupted valid bit in either pipeline register shows up at the ports within two edges. It appears as a missing, duplicated or early result, and the in-order comparison catches it immediately. A wrong stage-1 product, select or logic result, or a wrong stage-2 rounding, shows up as a wrong `outPix` value on the same transfer. Extreme byte values are used to reach the rounding and saturation corners. A stall that fails to freeze the second register changes `outPix` on the cycle after `outReady` falls.

// File: rtl/pix_combine_pkg.sv
package pix_combine_pkg;
  localparam int NUM_CH = 4;
  localparam int OP_W   = 4;
  localparam int SEL_W  = 3;

  typedef enum logic [OP_W-1:0] {
    OP_PASS   = 4'd0,  OP_AND    = 4'd1,  OP_SNOTD  = 4'd2,  OP_SRC    = 4'd3,
    OP_NSANDD = 4'd4,  OP_ZERO   = 4'd5,  OP_XOR    = 4'd6,  OP_OR     = 4'd7,
    OP_NOR    = 4'd8,  OP_XNOR   = 4'd9,  OP_NDST   = 4'd10, OP_SORND  = 4'd11,
    OP_NSRC   = 4'd12, OP_NSORD  = 4'd13, OP_NAND   = 4'd14, OP_ONES   = 4'd15
  } logicOp_e;

  typedef enum logic [SEL_W-1:0] {
    W_DST_A  = 3'd0,
    W_NDST_A = 3'd1,
    W_SRC_A  = 3'd2,
    W_NSRC_A = 3'd3,
    W_COEF   = 3'd4
  } weightSel_e;

  // Strobes from the pipeline control to the datapath registers.
  typedef struct packed {
    logic loadFirst;
    logic loadSecond;
  } pipeStb_t;
endpackage

// File: rtl/pix_combine_ctrl.sv
module pix_combine_ctrl
  import pix_combine_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     inValid,
  input  logic     outReady,
  output logic     inReady,
  output logic     outValid,
  output pipeStb_t stb
);
  logic firstValid, secondValid, advance;

  // The whole pipe moves unless a finished result is blocked downstream.
  assign advance = !(secondValid && !outReady);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      firstValid  <= 1'b0;
      secondValid <= 1'b0;
    end else if (advance) begin
      firstValid  <= inValid;
      secondValid <= firstValid;
    end
  end

  assign inReady        = advance;
  assign outValid       = secondValid;
  assign stb.loadFirst  = advance && inValid;
  assign stb.loadSecond = advance && firstValid;
endmodule

// File: rtl/pix_combine_dp.sv
module pix_combine_dp
  import pix_combine_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  pipeStb_t               stb,
  input  logic                   cfgBlend,
  input  logic [OP_W-1:0]        cfgColorOp,
  input  logic [OP_W-1:0]        cfgAlphaOp,
  input  logic [SEL_W-1:0]       cfgColXSel,
  input  logic [SEL_W-1:0]       cfgColYSel,
  input  logic [SEL_W-1:0]       cfgAlpXSel,
  input  logic [SEL_W-1:0]       cfgAlpYSel,
  input  logic [CH_W-1:0]        cfgCoefX,
  input  logic [CH_W-1:0]        cfgCoefY,
  input  logic [NUM_CH*CH_W-1:0] inDst,
  input  logic [NUM_CH*CH_W-1:0] inSrc,
  output logic [NUM_CH*CH_W-1:0] outPix
);
  localparam int PROD_W = 2 * CH_W;
  localparam int SUM_W  = PROD_W + 1;
  localparam int ALPHA  = NUM_CH - 1;
  localparam logic [SUM_W:0]  HALF = (SUM_W+1)'(1) << (CH_W - 1);
  localparam logic [CH_W-1:0] FULL = {CH_W{1'b1}};

  function automatic logic [CH_W-1:0] applyOp(input logic [OP_W-1:0] op,
                                               input logic [CH_W-1:0] s,
                                               input logic [CH_W-1:0] d);
    case (logicOp_e'(op))
      OP_PASS:   return d;
      OP_AND:    return s & d;
      OP_SNOTD:  return s & ~d;
      OP_SRC:    return s;
      OP_NSANDD: return ~s & d;
      OP_ZERO:   return '0;
      OP_XOR:    return s ^ d;
      OP_OR:     return s | d;
      OP_NOR:    return ~(s | d);
      OP_XNOR:   return ~(s ^ d);
      OP_NDST:   return ~d;
      OP_SORND:  return s | ~d;
      OP_NSRC:   return ~s;
      OP_NSORD:  return ~s | d;
      OP_NAND:   return ~(s & d);
      default:   return FULL;
    endcase
  endfunction

  function automatic logic [CH_W-1:0] pickWeight(input logic [SEL_W-1:0] sel,
                                                 input logic [CH_W-1:0] dA,
                                                 input logic [CH_W-1:0] sA,
                                                 input logic [CH_W-1:0] coef);
    case (sel)
      W_DST_A:  return dA;
      W_NDST_A: return FULL - dA;
      W_SRC_A:  return sA;
      W_NSRC_A: return FULL - sA;
      W_COEF:   return coef;
      default:  return '0;
    endcase
  endfunction

  function automatic logic [CH_W-1:0] rescale(input logic [SUM_W-1:0] p);
    logic [SUM_W:0] t;
    logic [SUM_W:0] q;
    t = {1'b0, p} + HALF;
    q = (t + (t >> CH_W)) >> CH_W;
    if (|q[SUM_W:CH_W]) return FULL;
    return q[CH_W-1:0];
  endfunction

  logic [CH_W-1:0] dstA, srcA;
  logic            firstBlend;

  assign dstA = inDst[ALPHA*CH_W +: CH_W];
  assign srcA = inSrc[ALPHA*CH_W +: CH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             firstBlend <= 1'b0;
    else if (stb.loadFirst) firstBlend <= cfgBlend;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    localparam bit IS_ALPHA = (ch == ALPHA);
    logic [CH_W-1:0]  chDst, chSrc, wX, wY, opRes, firstOp, lastOut;
    logic [PROD_W-1:0] prodX, prodY;
    logic [SUM_W-1:0]  firstSum;

    assign chDst = inDst[ch*CH_W +: CH_W];
    assign chSrc = inSrc[ch*CH_W +: CH_W];
    assign opRes = applyOp(IS_ALPHA ? cfgAlphaOp : cfgColorOp, chSrc, chDst);
    assign wX    = pickWeight(IS_ALPHA ? cfgAlpXSel : cfgColXSel, dstA, srcA, cfgCoefX);
    assign wY    = pickWeight(IS_ALPHA ? cfgAlpYSel : cfgColYSel, dstA, srcA, cfgCoefY);
    assign prodX = {{CH_W{1'b0}}, wX} * {{CH_W{1'b0}}, chDst};
    assign prodY = {{CH_W{1'b0}}, wY} * {{CH_W{1'b0}}, chSrc};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        firstOp  <= '0;
        firstSum <= '0;
        lastOut  <= '0;
      end else begin
        if (stb.loadFirst) begin
          firstOp  <= opRes;
          firstSum <= {1'b0, prodX} + {1'b0, prodY};
        end
        if (stb.loadSecond)
          lastOut <= firstBlend ? rescale(firstSum) : firstOp;
      end
    end

    assign outPix[ch*CH_W +: CH_W] = lastOut;
  end
endmodule

// File: rtl/pix_combine.sv
module pix_combine
  import pix_combine_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfgBlend,
  input  logic [OP_W-1:0]        cfgColorOp,
  input  logic [OP_W-1:0]        cfgAlphaOp,
  input  logic [SEL_W-1:0]       cfgColXSel,
  input  logic [SEL_W-1:0]       cfgColYSel,
  input  logic [SEL_W-1:0]       cfgAlpXSel,
  input  logic [SEL_W-1:0]       cfgAlpYSel,
  input  logic [CH_W-1:0]        cfgCoefX,
  input  logic [CH_W-1:0]        cfgCoefY,
  input  logic                   inValid,
  output logic                   inReady,
  input  logic [NUM_CH*CH_W-1:0] inDst,
  input  logic [NUM_CH*CH_W-1:0] inSrc,
  output logic                   outValid,
  input  logic                   outReady,
  output logic [NUM_CH*CH_W-1:0] outPix
);
  pipeStb_t stb;

  pix_combine_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .outReady(outReady),
    .inReady(inReady), .outValid(outValid), .stb(stb)
  );

  pix_combine_dp #(.CH_W(CH_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .cfgBlend(cfgBlend),
    .cfgColorOp(cfgColorOp), .cfgAlphaOp(cfgAlphaOp),
    .cfgColXSel(cfgColXSel), .cfgColYSel(cfgColYSel),
    .cfgAlpXSel(cfgAlpXSel), .cfgAlpYSel(cfgAlpYSel),
    .cfgCoefX(cfgCoefX), .cfgCoefY(cfgCoefY),
    .inDst(inDst), .inSrc(inSrc), .outPix(outPix)
  );
endmodule

// File: rtl/pix_combine_chk.sv
module pix_combine_chk #(
  parameter int PIX_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             inReady,
  input logic             outValid,
  input logic             outReady,
  input logic [PIX_W-1:0] outPix
);
  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outPix)));

  assert_ready_only_on_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !inReady |-> (outValid && !outReady));

  assert_two_edge_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inReady) |=> ##1 outValid);

  assert_no_phantom_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outValid) |-> $past(inValid && inReady, 2));

  assert_reset_idle_R3: assert property (@(posedge clk)
    !rst_n |=> !outValid);
endmodule

bind pix_combine pix_combine_chk #(.PIX_W(4*CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outPix(outPix)
);

// File: tb/pix_combine_bench.sv
module pix_combine_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfgBlend = 1'b0;
  logic [3:0] cfgColorOp = 4'd3, cfgAlphaOp = 4'd3;
  logic [2:0] cfgColXSel = 3'd0, cfgColYSel = 3'd0, cfgAlpXSel = 3'd0, cfgAlpYSel = 3'd0;
  logic [7:0] cfgCoefX = 8'd0, cfgCoefY = 8'd0;
  logic inValid = 1'b0, outReady = 1'b1;
  logic inReady, outValid;
  logic [31:0] inDst = '0, inSrc = '0, outPix;

  int checks = 0, errors = 0;
  logic [31:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pix_combine u_pix_combine (.*);

  function automatic logic [7:0] refOp(input logic [3:0] op, input logic [7:0] s, input logic [7:0] d);
    case (op)
      4'd0: return d;          4'd1: return s & d;
      4'd2: return s & ~d;     4'd3: return s;
      4'd4: return ~s & d;     4'd5: return 8'h00;
      4'd6: return s ^ d;      4'd7: return s | d;
      4'd8: return ~(s | d);   4'd9: return ~(s ^ d);
      4'd10: return ~d;        4'd11: return s | ~d;
      4'd12: return ~s;        4'd13: return ~s | d;
      4'd14: return ~(s & d);  default: return 8'hFF;
    endcase
  endfunction

  function automatic int refWeight(input logic [2:0] sel, input int da, input int sa, input int coef);
    case (sel)
      3'd0: return da;      3'd1: return 255 - da;
      3'd2: return sa;      3'd3: return 255 - sa;
      3'd4: return coef;    default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] refScale(input int p);
    int q;
    q = (p + 128 + ((p + 128) >> 8)) >> 8;
    return (q > 255) ? 8'hFF : 8'(q);
  endfunction

  function automatic logic [31:0] model(input logic [31:0] d, input logic [31:0] s);
    logic [31:0] r;
    int da, sa;
    da = int'(d[31:24]);
    sa = int'(s[31:24]);
    for (int ch = 0; ch < 4; ch++) begin
      int dv, sv, x, y;
      dv = int'(d[ch*8 +: 8]);
      sv = int'(s[ch*8 +: 8]);
      if (!cfgBlend)
        r[ch*8 +: 8] = refOp(ch == 3 ? cfgAlphaOp : cfgColorOp, s[ch*8 +: 8], d[ch*8 +: 8]);
      else begin
        x = refWeight(ch == 3 ? cfgAlpXSel : cfgColXSel, da, sa, int'(cfgCoefX));
        y = refWeight(ch == 3 ? cfgAlpYSel : cfgColYSel, da, sa, int'(cfgCoefY));
        r[ch*8 +: 8] = refScale(x * dv + y * sv);
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] genPix(input bit extreme);
    logic [31:0] v;
    if (!extreme) return $urandom;
    for (int b = 0; b < 4; b++)
      case ($urandom % 6)
        0: v[b*8 +: 8] = 8'd0;   1: v[b*8 +: 8] = 8'd1;
        2: v[b*8 +: 8] = 8'd127; 3: v[b*8 +: 8] = 8'd128;
        4: v[b*8 +: 8] = 8'd254; default: v[b*8 +: 8] = 8'd255;
      endcase
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runStream(input string req, input int n, input bit stall, input bit extreme);
    int sent = 0, got = 0, guard = 0;
    bit wasBlocked = 0;
    logic [31:0] heldPix = '0;
    while (got < n && guard < 20000) begin
      inValid  = (sent < n) && (!stall || ($urandom % 4 != 0));
      inDst    = genPix(extreme);
      inSrc    = genPix(extreme);
      outReady = !stall || ($urandom % 3 != 0);
      #1;
      if (wasBlocked) begin
        check("R2 held valid", {31'd0, outValid}, 32'd1);
        check("R2 held pixel", outPix, heldPix);
      end
      if (outValid && outReady) begin
        if (expQ.size() == 0) check({req, " unexpected result"}, outPix, 32'hx);
        else check(req, outPix, expQ.pop_front());
        got++;
      end
      if (inValid && inReady) begin
        expQ.push_back(model(inDst, inSrc));
        sent++;
      end
      wasBlocked = outValid && !outReady;
      heldPix    = outPix;
      tick();
      guard++;
    end
    inValid = 1'b0;
    outReady = 1'b1;
    check({req, " drained"}, 32'(expQ.size()), 32'd0);
    expQ.delete();
  endtask

  task automatic one(input string req, input logic [31:0] d, input logic [31:0] s, input logic [31:0] exp);
    inValid = 1'b1; inDst = d; inSrc = s; outReady = 1'b1;
    tick();
    inValid = 1'b0;
    tick();
    #1;
    check({req, " valid"}, {31'd0, outValid}, 32'd1);
    check(req, outPix, exp);
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    #1;
    check("R3 outValid in reset", {31'd0, outValid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    #1;
    check("R3 outValid after reset", {31'd0, outValid}, 32'd0);
    @(negedge clk);

    // R1: exact latency with copy code
    cfgColorOp = 4'd3; cfgAlphaOp = 4'd3;
    inValid = 1'b1; inDst = 32'h11223344; inSrc = 32'hA5B6C7D8; outReady = 1'b1;
    #1;
    check("R1 ready when idle", {31'd0, inReady}, 32'd1);
    tick();
    inValid = 1'b0;
    #1;
    check("R1 not valid after one edge", {31'd0, outValid}, 32'd0);
    tick();
    #1;
    check("R1 valid after two edges", {31'd0, outValid}, 32'd1);
    check("R1 latency data", outPix, 32'hA5B6C7D8);
    tick();
    runStream("R1 ordered stream", 40, 1'b1, 1'b0);

    // R6: pass-through ignores source
    cfgColorOp = 4'd0; cfgAlphaOp = 4'd0;
    one("R6 pass", 32'h01234567, 32'hFFFFFFFF, 32'h01234567);
    runStream("R6 pass stream", 30, 1'b1, 1'b0);

    // R4: every colour code, alpha on a different code
    for (int op = 0; op < 16; op++) begin
      cfgColorOp = 4'(op);
      cfgAlphaOp = 4'(op) ^ 4'd5;
      runStream($sformatf("R4 code %0d", op), 10, 1'b1, 1'b0);
    end

    // R5: alpha code independent of colour code
    cfgColorOp = 4'd3; cfgAlphaOp = 4'd5;
    one("R5 alpha cleared", 32'h12345678, 32'hABCDEF01, 32'h00CDEF01);
    cfgColorOp = 4'd5; cfgAlphaOp = 4'd15;
    one("R5 alpha set", 32'h12345678, 32'hABCDEF01, 32'hFF000000);

    // R10: source-over
    cfgBlend = 1'b1;
    cfgColXSel = 3'd3; cfgColYSel = 3'd2; cfgAlpXSel = 3'd3; cfgAlpYSel = 3'd4;
    cfgCoefY = 8'd255;
    one("R10 opaque source", 32'h40506070, 32'hFF102030, 32'hFF102030);
    one("R10 clear source", 32'h40506070, 32'h00102030, 32'h40506070);
    runStream("R10 source-over", 40, 1'b1, 1'b1);

    // R7: rounding and saturation
    cfgColXSel = 3'd4; cfgColYSel = 3'd4; cfgAlpXSel = 3'd4; cfgAlpYSel = 3'd4;
    cfgCoefX = 8'd255; cfgCoefY = 8'd255;
    one("R7 saturate", 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF);
    cfgColYSel = 3'd5; cfgAlpYSel = 3'd5; cfgCoefX = 8'd128;
    one("R7 round up", 32'h01010101, 32'hFFFFFFFF, 32'h01010101);
    cfgCoefX = 8'd255;
    one("R7 exact", 32'h80808080, 32'hFFFFFFFF, 32'h80808080);

    // R8: all select values including the zero codes
    for (int k = 0; k < 20; k++) begin
      cfgColXSel = 3'($urandom); cfgColYSel = 3'($urandom);
      cfgAlpXSel = 3'($urandom); cfgAlpYSel = 3'($urandom);
      cfgCoefX = 8'($urandom); cfgCoefY = 8'($urandom);
      runStream($sformatf("R8 selects %0d%0d%0d%0d", cfgColXSel, cfgColYSel, cfgAlpXSel, cfgAlpYSel),
                8, k[0], k[1]);
    end

    // R9: X and Y coefficients are distinct
    cfgColXSel = 3'd4; cfgColYSel = 3'd6; cfgAlpXSel = 3'd7; cfgAlpYSel = 3'd4;
    cfgCoefX = 8'd255; cfgCoefY = 8'd0;
    one("R9 X uses coefX", 32'h99887766, 32'h11223344, 32'h00887766);
    cfgCoefX = 8'd0; cfgCoefY = 8'd255;
    one("R9 Y uses coefY", 32'h99887766, 32'h11223344, 32'h11000000);
    for (int k = 0; k < 8; k++) begin
      cfgColXSel = 3'd4; cfgColYSel = 3'd4; cfgAlpXSel = 3'd4; cfgAlpYSel = 3'd4;
      cfgCoefX = 8'($urandom); cfgCoefY = 8'($urandom);
      runStream("R9 coefficients", 8, 1'b1, 1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule